// File: doc/BRIEF.md
# Twisted-pair link integrity monitor

This block decides whether a 10BASE-T link partner is present. The receive front end hands it a one-cycle strobe for each link pulse it sees and a level that is high while a frame is being received. From these the block keeps a link state and drives a single link status bit. Pulses that follow the previous accepted pulse too closely are treated as noise. A silence longer than the link-loss window drops the link. From the failed state the link comes back after a run of consecutive accepted pulses, or at once when frame activity is seen.

A control input pins the monitor in a forced-good state, so the status bit reads 1 with no partner attached. Clearing that control puts the monitor back into normal monitoring with a fresh link-loss window, so the link is not dropped at that moment. When the port multiplexer selects the auxiliary attachment-unit interface instead of the twisted pair, monitoring stops. State, timers and pulse counts are held and pulses are ignored. All time limits are parameters counted in clock cycles.

Top module: `link_integrity_mon`

## Requirements
- R1: While reset is asserted and on the cycles after it is released with the override low, `state_o` reads 2'b00 (failed) and `link_o` reads 0. The state code 2'b10 never appears.
- R2: When `force_good_i` is sampled high at a clock edge, from the next cycle `state_o` reads 2'b11 (forced good) and `link_o` reads 1, whatever pulses or activity arrive.
- R3: If `force_good_i` is high when reset is released, the forced-good state is in place after the first clock edge.
- R4: In the good state (2'b01), with the twisted pair selected and no accepted pulse and no receive activity, the state falls to 2'b00 exactly `LOSS_CYCLES` edges after the edge that last restarted the window.
- R5: An accepted pulse or a cycle of `rx_active_i` restarts the link-loss window.
- R6: A pulse arriving fewer than `MIN_GAP` cycles after the previous accepted pulse is rejected. It neither restarts the window nor counts toward recovery.
- R7: From the failed state, `GOOD_PULSES` accepted pulses move the state to good, provided each comes within `LOSS_CYCLES` cycles of the one before. If that window runs out, the count starts over.
- R8: From the failed state, a cycle of `rx_active_i` moves the state to good on the next edge.
- R9: While `aux_port_sel_i` is high and the override is low, the state does not change and pulses are neither counted nor used to restart the window.
- R10: When the override is cleared while in forced good, the next state is good (2'b01). The link-loss window is restarted at that edge, so the link drops no earlier than `LOSS_CYCLES` edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | One-cycle strobe per received link pulse |
| rx_active_i | input | 1 | High while frame reception is in progress |
| force_good_i | input | 1 | Override: pin the monitor in forced good |
| aux_port_sel_i | input | 1 | Auxiliary interface selected; monitoring frozen |
| link_o | output | 1 | Link status bit, 1 when link is good or forced |
| state_o | output | 2 | 2'b00 failed, 2'b01 good, 2'b11 forced good |

## Verification
On every cycle the assertions check several properties. The override reaches forced good on the next cycle, and leaving the override lands in good. The frozen interface keeps the state still. The failed state does not move without a pulse or activity. Accepted pulses are never back to back, and a link drop is always preceded by a quiet cycle. The exact edge on which the loss window expires can only be shown by the bench scenarios. The same holds for a rejected pulse failing to extend that window, for the recovery count restarting after a long silence, and for the fresh window after the override is released.

// File: rtl/lim_pkg.sv
package lim_pkg;

   typedef enum logic [1:0] {
      LK_FAIL   = 2'b00,
      LK_GOOD   = 2'b01,
      LK_FORCED = 2'b11
   } lk_state_e;

   function automatic logic lk_is_up(input lk_state_e st);
      return st != LK_FAIL;
   endfunction

endpackage

// File: rtl/lim_gap_qual.sv
module lim_gap_qual #(
   parameter int unsigned MIN_GAP = 100_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic pulse_i,
   output logic valid_o
);

   generate
      if (MIN_GAP <= 1) begin : g_no_gap
         assign valid_o = pulse_i && !hold_i;
      end else begin : g_gap
         localparam int unsigned GW  = $clog2(MIN_GAP);
         localparam logic [GW-1:0] SAT = GW'(MIN_GAP - 1);
         logic [GW-1:0] gap_q;

         assign valid_o = pulse_i && !hold_i && (gap_q == SAT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gap_q <= SAT;
            end else if (!hold_i) begin
               if (valid_o) begin
                  gap_q <= '0;
               end else if (gap_q != SAT) begin
                  gap_q <= gap_q + 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lim_loss_timer.sv
module lim_loss_timer #(
   parameter int unsigned LOSS_CYCLES = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic expire_o
);

   localparam int unsigned TW  = $clog2(LOSS_CYCLES);
   localparam logic [TW-1:0] LAST = TW'(LOSS_CYCLES - 1);

   logic [TW-1:0] cnt_q;

   assign expire_o = run_i && !restart_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i || expire_o) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/lim_pulse_count.sv
module lim_pulse_count #(
   parameter int unsigned GOOD_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic reached_o
);

   generate
      if (GOOD_PULSES == 1) begin : g_single
         assign reached_o = inc_i;
      end else begin : g_multi
         localparam int unsigned CW = $clog2(GOOD_PULSES);
         localparam logic [CW-1:0] LAST = CW'(GOOD_PULSES - 1);
         logic [CW-1:0] cnt_q;

         assign reached_o = inc_i && !clr_i && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr_i || reached_o) begin
               cnt_q <= '0;
            end else if (inc_i) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
   import lim_pkg::*;
#(
   parameter int unsigned LOSS_CYCLES = 5_000_000,
   parameter int unsigned MIN_GAP     = 100_000,
   parameter int unsigned GOOD_PULSES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pulse_i,
   input  logic       rx_active_i,
   input  logic       force_good_i,
   input  logic       aux_port_sel_i,
   output logic       link_o,
   output logic [1:0] state_o
);

   generate
      if (LOSS_CYCLES < 2) begin : g_bad_loss
         $error("LOSS_CYCLES must be at least 2");
      end
      if (MIN_GAP < 1 || MIN_GAP >= LOSS_CYCLES) begin : g_bad_gap
         $error("MIN_GAP must be in 1 .. LOSS_CYCLES-1");
      end
      if (GOOD_PULSES < 1) begin : g_bad_cnt
         $error("GOOD_PULSES must be at least 1");
      end
   endgenerate

   lk_state_e st_q, st_d;
   logic      pulse_ok;
   logic      expire;
   logic      restart;
   logic      reached;
   logic      cnt_clr;
   logic      cnt_inc;
   logic      frozen;
   logic      in_fail;

   assign frozen  = aux_port_sel_i;
   assign in_fail = (st_q == LK_FAIL) && !force_good_i;

   lim_gap_qual #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_i  (frozen),
      .pulse_i (pulse_i),
      .valid_o (pulse_ok)
   );

   // Window restarts on activity, and is held cleared while forced.
   assign restart = force_good_i || (st_q == LK_FORCED) ||
                    (!frozen && (pulse_ok || rx_active_i));

   lim_loss_timer #(.LOSS_CYCLES(LOSS_CYCLES)) u_loss (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (!frozen),
      .restart_i (restart),
      .expire_o  (expire)
   );

   assign cnt_inc = in_fail && pulse_ok;
   assign cnt_clr = !in_fail || expire || (rx_active_i && !frozen);

   lim_pulse_count #(.GOOD_PULSES(GOOD_PULSES)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (cnt_clr),
      .inc_i     (cnt_inc),
      .reached_o (reached)
   );

   always_comb begin
      st_d = st_q;
      if (force_good_i) begin
         st_d = LK_FORCED;
      end else begin
         unique case (st_q)
            LK_FORCED: st_d = LK_GOOD;
            LK_GOOD:   if (expire) st_d = LK_FAIL;
            LK_FAIL:   if (!frozen && (rx_active_i || reached)) st_d = LK_GOOD;
            default:   st_d = LK_FAIL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= LK_FAIL;
      end else begin
         st_q <= st_d;
      end
   end

   assign state_o = st_q;
   assign link_o  = lk_is_up(st_q);

endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
   parameter int unsigned MIN_GAP = 100_000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pulse_i,
   input logic       rx_active_i,
   input logic       force_good_i,
   input logic       aux_port_sel_i,
   input logic       link_o,
   input logic [1:0] state_o,
   input logic       pulse_ok
);

   localparam bit SPACED = (MIN_GAP > 1);

   a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'b10);

   a_r2_override_forces: assert property (@(posedge clk) disable iff (!rst_n)
      force_good_i |=> (state_o == 2'b11 && link_o));

   a_r4_drop_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_o) |-> $past(!rx_active_i && !pulse_ok && !force_good_i && !aux_port_sel_i));

   a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (SPACED && pulse_ok) |=> !pulse_ok);

   a_r7_fail_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && !force_good_i && !rx_active_i && !pulse_i) |=> state_o == 2'b00);

   a_r9_aux_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_port_sel_i && !force_good_i && state_o != 2'b11) |=> $stable(state_o));

   a_r10_release_to_good: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11 && !force_good_i) |=> state_o == 2'b01);

endmodule

bind link_integrity_mon lim_checker #(.MIN_GAP(MIN_GAP)) u_lim_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .pulse_i        (pulse_i),
   .rx_active_i    (rx_active_i),
   .force_good_i   (force_good_i),
   .aux_port_sel_i (aux_port_sel_i),
   .link_o         (link_o),
   .state_o        (state_o),
   .pulse_ok       (pulse_ok)
);

// File: tb/link_integrity_mon_bench.sv
module link_integrity_mon_bench;

   localparam int unsigned LOSS = 200;
   localparam int unsigned GAP  = 20;
   localparam int unsigned NP   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pulse_i = 1'b0;
   logic       rx_active_i = 1'b0;
   logic       force_good_i = 1'b0;
   logic       aux_port_sel_i = 1'b0;
   logic       link_o;
   logic [1:0] state_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   link_integrity_mon #(.LOSS_CYCLES(LOSS), .MIN_GAP(GAP), .GOOD_PULSES(NP)) u_link_integrity_mon (
      .clk            (clk),
      .rst_n          (rst_n),
      .pulse_i        (pulse_i),
      .rx_active_i    (rx_active_i),
      .force_good_i   (force_good_i),
      .aux_port_sel_i (aux_port_sel_i),
      .link_o         (link_o),
      .state_o        (state_o)
   );

   typedef struct packed {
      logic        pls;
      logic        rx;
      logic        frc;
      logic        aux;
      logic [15:0] wt;
      logic [1:0]  exp;
      logic [3:0]  req;
   } vec_t;

   // Each entry: drive one cycle, clear strobes, wait wt cycles, compare.
   // Consecutive strobes land wt+2 edges apart.
   localparam vec_t TBL [20] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'd18,  2'b00, 4'd7},  // R7 first pulse counted
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'd0,   2'b01, 4'd7},  // R7 second pulse -> good
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'd3,   2'b01, 4'd6},  // R6 pulse too early
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'd192, 2'b01, 4'd4},  // R4 one edge before loss
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'd0,   2'b00, 4'd6},  // R6 early pulse did not extend
      '{1'b0, 1'b1, 1'b0, 1'b0, 16'd0,   2'b01, 4'd8},  // R8 activity recovers
      '{1'b0, 1'b1, 1'b0, 1'b0, 16'd0,   2'b01, 4'd5},  // R5 activity restarts
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'd196, 2'b01, 4'd5},  // R5 window counted from restart
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'd0,   2'b00, 4'd4},  // R4 loss
      '{1'b0, 1'b0, 1'b0, 1'b1, 16'd300, 2'b00, 4'd9},  // R9 frozen
      '{1'b1, 1'b0, 1'b0, 1'b1, 16'd30,  2'b00, 4'd9},  // R9 pulse ignored
      '{1'b1, 1'b0, 1'b0, 1'b1, 16'd0,   2'b00, 4'd9},  // R9 pulse ignored
      '{1'b0, 1'b0, 1'b1, 1'b0, 16'd0,   2'b11, 4'd2},  // R2 forced
      '{1'b1, 1'b0, 1'b1, 1'b0, 16'd400, 2'b11, 4'd2},  // R2 forced past window
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'd0,   2'b01, 4'd10}, // R10 release to good
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'd196, 2'b01, 4'd10}, // R10 fresh window
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'd0,   2'b00, 4'd10}, // R10 drops after window
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'd210, 2'b00, 4'd7},  // R7 count expires
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'd18,  2'b00, 4'd7},  // R7 count restarted
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'd0,   2'b01, 4'd7}   // R7 recovered
   };

   task automatic check(input string tag, input logic [1:0] exp_st);
      n_run++;
      if (state_o !== exp_st || link_o !== (exp_st != 2'b00)) begin
         n_fail++;
         $display("FAIL %s: state=%b link=%b expected state=%b link=%b",
                  tag, state_o, link_o, exp_st, exp_st != 2'b00);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check("R1 in reset", 2'b00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after reset", 2'b00);

      foreach (TBL[i]) begin
         @(negedge clk);
         pulse_i        = TBL[i].pls;
         rx_active_i    = TBL[i].rx;
         force_good_i   = TBL[i].frc;
         aux_port_sel_i = TBL[i].aux;
         @(negedge clk);
         pulse_i     = 1'b0;
         rx_active_i = 1'b0;
         for (int w = 0; w < int'(TBL[i].wt); w++) @(negedge clk);
         check($sformatf("R%0d step %0d", TBL[i].req, i), TBL[i].exp);
      end

      // R3: override held through reset release
      @(negedge clk);
      rst_n        = 1'b0;
      force_good_i = 1'b1;
      @(negedge clk);
      check("R1 override ignored in reset", 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 forced on first edge", 2'b11);
      force_good_i = 1'b0;
      @(negedge clk);
      check("R10 release after reset", 2'b01);

      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

endmodule